// File: doc/BRIEF.md
# Banked 20-bit Effective Address Generator

This block forms the effective address for a 16-bit processor whose pointer registers carry a 4-bit bank field above them. It takes the index registers X, Y and Z with their bank fields, the program counter with its bank field, the accumulators D and E, a 20-bit operand word and the data bank field. From these it computes a 20-bit linear address from a 4-bit bank and a 16-bit page offset. For the modes that update a pointer, it also produces a write-back value and the number of the index register that receives it.

Each offset form has its own mode code: unsigned byte, signed word, signed 20-bit, accumulator offset, absolute extended, post-modify, PC-relative and add-immediate. A sum that carries across a 64 KB bank boundary changes the upper address bits. The stored bank field of the index register changes only in the modes that raise the write-back flag. The address driven outward is 24 bits wide, and its top nibble repeats bit 19.

The arithmetic is combinational. All results are captured in one output register stage, and that stage loads only when the request strobe is high. The results are valid on the clock after the strobe and hold until the next strobe.

Top module: `bank_ea_gen`

## Requirements
- R1: Mode 0 (unsigned byte index) gives ea = ({bank,index} + zero-extended operand[7:0]) mod 2^20. The index is chosen by `idx_sel`: 0 = X, 1 = Y, 2 = Z, 3 = X. A carry out of the index changes ea[19:16], and wb_en stays 0.
- R2: Mode 1 (signed word index) gives ea = ({bank,index} + sign-extended operand[15:0]) mod 2^20, with wb_en = 0.
- R3: Mode 2 (20-bit index, used for jump targets) gives ea = ({bank,index} + operand[19:0]) mod 2^20.
- R4: Mode 3 adds accumulator E, and mode 8 adds accumulator D. In both, the accumulator is sign-extended to 20 bits and added to the selected {bank,index}, modulo 2^20.
- R5: Mode 4 (extended) gives ea = {dext, operand[15:0]}.
- R6: Mode 5 (post-modify) gives ea = {xk,ix}. It raises wb_en with wb_sel = 0 (X), and wb_val = ({xk,ix} + sign-extended operand[7:0]) mod 2^20.
- R7: Mode 6 (relative) uses a sign-extended offset: operand[15:0] when `rel_word` = 1, operand[7:0] otherwise. When `br_taken` = 1, ea = {pk, (pc + offset) mod 2^16}. When `br_taken` = 0, ea = {pk, pc}. The bank field pk is never changed.
- R8: Mode 7 (add immediate) gives ea = wb_val = ({bank,index} + sign-extended operand[7:0]) mod 2^20. It raises wb_en, and wb_sel names the chosen register (0 = X, 1 = Y, 2 = Z).
- R9: ext_addr[19:0] equals ea, and ext_addr[23:20] each equal ea[19].
- R10: `vld` is high for exactly the one clock after a clock edge that samples `req` high. When `req` is low, ea, ext_addr, wb_en, wb_sel and wb_val keep their values.
- R11: While `rst` is high, vld, ea, ext_addr, wb_en, wb_sel and wb_val are all 0.
- R12: Mode codes 9 to 15 give ea = 0 and wb_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe; loads the output stage |
| mode | input | 4 | Addressing form code |
| idx_sel | input | 2 | Index register choice (0 X, 1 Y, 2 Z, 3 X) |
| rel_word | input | 1 | Relative offset width: 1 word, 0 byte |
| br_taken | input | 1 | Branch condition result for relative mode |
| xk | input | 4 | Bank field of X |
| ix | input | 16 | Index register X |
| yk | input | 4 | Bank field of Y |
| iy | input | 16 | Index register Y |
| zk | input | 4 | Bank field of Z |
| iz | input | 16 | Index register Z |
| pk | input | 4 | Bank field of the program counter |
| pc | input | 16 | Program counter |
| acc_d | input | 16 | Accumulator D |
| acc_e | input | 16 | Accumulator E |
| opnd | input | 20 | Immediate, offset or absolute operand |
| dext | input | 4 | Data bank field |
| vld | output | 1 | Results valid this cycle |
| ea | output | 20 | Effective address |
| ext_addr | output | 24 | Outward address, top nibble copies bit 19 |
| wb_en | output | 1 | Write-back of an index register requested |
| wb_sel | output | 2 | Register receiving the write-back |
| wb_val | output | 20 | Write-back value, bank and index |

## Verification
The assertions sample the mode, the operands and the registers at the edge where `req` is high. They take for granted that these inputs are steady at that edge and that `mode` carries one of the sixteen codes. The bench changes every input on the falling edge only and holds it through the following rising edge. It drops `req` before it samples, so each vector is loaded exactly once. The checks of the hold behaviour then change the inputs while `req` is low.

// File: rtl/bea_pkg.sv
package bea_pkg;
  typedef enum logic [3:0] {
    M_IDX8U  = 4'd0,
    M_IDX16S = 4'd1,
    M_IDX20S = 4'd2,
    M_ACCE   = 4'd3,
    M_EXT    = 4'd4,
    M_POST   = 4'd5,
    M_REL    = 4'd6,
    M_AIMM   = 4'd7,
    M_ACCD   = 4'd8
  } ea_mode_e;

  localparam logic [3:0] M_LAST = 4'd8;
  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;
endpackage

// File: rtl/bea_base_sel.sv
module bea_base_sel #(
  parameter int PW = 16,
  parameter int XW = 4,
  localparam int AW = PW + XW
) (
  input  logic [1:0]    idx_sel,
  input  logic [XW-1:0] xk,
  input  logic [PW-1:0] ix,
  input  logic [XW-1:0] yk,
  input  logic [PW-1:0] iy,
  input  logic [XW-1:0] zk,
  input  logic [PW-1:0] iz,
  output logic [AW-1:0] base,
  output logic [1:0]    sel_n
);
  import bea_pkg::*;

  always_comb begin
    case (idx_sel)
      SEL_Y:   begin base = {yk, iy}; sel_n = SEL_Y; end
      SEL_Z:   begin base = {zk, iz}; sel_n = SEL_Z; end
      default: begin base = {xk, ix}; sel_n = SEL_X; end
    endcase
  end
endmodule

// File: rtl/bea_off_gen.sv
module bea_off_gen #(
  parameter int PW = 16,
  parameter int XW = 4,
  localparam int AW = PW + XW
) (
  input  logic [3:0]    mode,
  input  logic          rel_word,
  input  logic [AW-1:0] opnd,
  input  logic [PW-1:0] acc_d,
  input  logic [PW-1:0] acc_e,
  output logic [AW-1:0] off
);
  import bea_pkg::*;

  logic [AW-1:0] z8, s8, s16, se, sd;

  assign z8  = {{(AW-8){1'b0}}, opnd[7:0]};
  assign s8  = {{(AW-8){opnd[7]}}, opnd[7:0]};
  assign s16 = {{XW{opnd[PW-1]}}, opnd[PW-1:0]};
  assign se  = {{XW{acc_e[PW-1]}}, acc_e};
  assign sd  = {{XW{acc_d[PW-1]}}, acc_d};

  always_comb begin
    case (mode)
      M_IDX8U:         off = z8;
      M_IDX16S:        off = s16;
      M_IDX20S:        off = opnd;
      M_ACCE:          off = se;
      M_ACCD:          off = sd;
      M_POST, M_AIMM:  off = s8;
      M_REL:           off = rel_word ? s16 : s8;
      default:         off = '0;
    endcase
  end
endmodule

// File: rtl/bea_calc.sv
module bea_calc #(
  parameter int PW = 16,
  parameter int XW = 4,
  localparam int AW = PW + XW
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    sel_n,
  input  logic          br_taken,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] xbase,
  input  logic [XW-1:0] pk,
  input  logic [PW-1:0] pc,
  input  logic [XW-1:0] dext,
  input  logic [PW-1:0] abs_word,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  import bea_pkg::*;

  logic [AW-1:0] sum, xsum;
  logic [PW-1:0] pc_next;

  assign sum     = base + off;
  assign xsum    = xbase + off;
  assign pc_next = pc + off[PW-1:0];

  always_comb begin
    ea     = '0;
    wb_en  = 1'b0;
    wb_sel = SEL_X;
    wb_val = '0;
    case (mode)
      M_IDX8U, M_IDX16S, M_IDX20S, M_ACCE, M_ACCD: ea = sum;
      M_EXT:  ea = {dext, abs_word};
      M_POST: begin
        ea     = xbase;
        wb_en  = 1'b1;
        wb_sel = SEL_X;
        wb_val = xsum;
      end
      M_REL:  ea = br_taken ? {pk, pc_next} : {pk, pc};
      M_AIMM: begin
        ea     = sum;
        wb_en  = 1'b1;
        wb_sel = sel_n;
        wb_val = sum;
      end
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen #(
  parameter int PW = 16,
  parameter int XW = 4,
  parameter int OW = 24,
  localparam int AW = PW + XW,
  localparam int PADW = OW - AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [3:0]    mode,
  input  logic [1:0]    idx_sel,
  input  logic          rel_word,
  input  logic          br_taken,
  input  logic [XW-1:0] xk,
  input  logic [PW-1:0] ix,
  input  logic [XW-1:0] yk,
  input  logic [PW-1:0] iy,
  input  logic [XW-1:0] zk,
  input  logic [PW-1:0] iz,
  input  logic [XW-1:0] pk,
  input  logic [PW-1:0] pc,
  input  logic [PW-1:0] acc_d,
  input  logic [PW-1:0] acc_e,
  input  logic [AW-1:0] opnd,
  input  logic [XW-1:0] dext,
  output logic          vld,
  output logic [AW-1:0] ea,
  output logic [OW-1:0] ext_addr,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  import bea_pkg::*;

  logic [AW-1:0] base, off, ea_c, wbv_c;
  logic [1:0]    sel_n, wbs_c;
  logic          wbe_c;

  bea_base_sel #(.PW(PW), .XW(XW)) u_base (
    .idx_sel(idx_sel), .xk(xk), .ix(ix), .yk(yk), .iy(iy),
    .zk(zk), .iz(iz), .base(base), .sel_n(sel_n)
  );

  bea_off_gen #(.PW(PW), .XW(XW)) u_off (
    .mode(mode), .rel_word(rel_word), .opnd(opnd),
    .acc_d(acc_d), .acc_e(acc_e), .off(off)
  );

  bea_calc #(.PW(PW), .XW(XW)) u_calc (
    .mode(mode), .sel_n(sel_n), .br_taken(br_taken), .base(base),
    .off(off), .xbase({xk, ix}), .pk(pk), .pc(pc), .dext(dext),
    .abs_word(opnd[PW-1:0]), .ea(ea_c), .wb_en(wbe_c),
    .wb_sel(wbs_c), .wb_val(wbv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= 1'b0;
      ea       <= '0;
      ext_addr <= '0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
    end else begin
      vld <= req;
      if (req) begin
        ea       <= ea_c;
        ext_addr <= {{PADW{ea_c[AW-1]}}, ea_c};
        wb_en    <= wbe_c;
        wb_sel   <= wbs_c;
        wb_val   <= wbv_c;
      end
    end
  end

  // R10: valid follows the strobe by one clock
  a_r10_vld_after_req: assert property (@(posedge clk) disable iff (rst)
    req |=> vld);
  // R10: no strobe, outputs held and not valid
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!vld && $stable(ea) && $stable(wb_val) && $stable(wb_en)));
  // R9: outward address mirrors ea with bit 19 repeated
  a_r9_upper_copy: assert property (@(posedge clk) disable iff (rst)
    vld |-> (ext_addr[AW-1:0] == ea &&
             ext_addr[OW-1:AW] == {PADW{ea[AW-1]}}));
  // R6: post-modify uses unmodified X as address
  a_r6_post_base: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_POST) |=> (ea == $past({xk, ix}) && wb_en && wb_sel == SEL_X));
  // R7: untaken branch keeps pc and its bank
  a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_REL && !br_taken) |=> (ea == $past({pk, pc}) && !wb_en));
  // R8: add-immediate writes back the same value it addresses
  a_r8_aimm_wb: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_AIMM) |=> (wb_en && wb_val == ea));
  // R12: unused codes give nothing
  a_r12_unused: assert property (@(posedge clk) disable iff (rst)
    (req && mode > M_LAST) |=> (!wb_en && ea == '0));
  // R5: extended address takes data bank and absolute word
  a_r5_ext: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_EXT) |=> (ea == $past({dext, opnd[PW-1:0]})));
endmodule

// File: tb/sim_bank_ea_gen.sv
module sim_bank_ea_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  idx_sel = '0;
  logic        rel_word = 1'b0, br_taken = 1'b0;
  logic [3:0]  xk = '0, yk = '0, zk = '0, pk = '0, dext = '0;
  logic [15:0] ix = '0, iy = '0, iz = '0, pc = '0, acc_d = '0, acc_e = '0;
  logic [19:0] opnd = '0;
  logic        vld, wb_en;
  logic [19:0] ea, wb_val;
  logic [23:0] ext_addr;
  logic [1:0]  wb_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bank_ea_gen u0 (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .idx_sel(idx_sel),
    .rel_word(rel_word), .br_taken(br_taken), .xk(xk), .ix(ix),
    .yk(yk), .iy(iy), .zk(zk), .iz(iz), .pk(pk), .pc(pc),
    .acc_d(acc_d), .acc_e(acc_e), .opnd(opnd), .dext(dext),
    .vld(vld), .ea(ea), .ext_addr(ext_addr), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, strobe once, sample on the falling edge after load
  task automatic issue(input logic [3:0] m, input logic [19:0] op);
    @(negedge clk);
    mode = m; opnd = op; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 vld", {23'd0, vld}, 24'd0);
    chk("R11 ea", {4'd0, ea}, 24'd0);
    chk("R11 ext_addr", ext_addr, 24'd0);
    chk("R11 wb_en", {23'd0, wb_en}, 24'd0);
    chk("R11 wb_val", {4'd0, wb_val}, 24'd0);
  endtask

  task automatic t_idx8;
    idx_sel = 2'd0; xk = 4'h3; ix = 16'hFFF0;
    issue(4'd0, 20'h000A0);
    chk("R1 ea bank carry", {4'd0, ea}, 24'h040090);
    chk("R1 wb_en", {23'd0, wb_en}, 24'd0);
    chk("R10 vld", {23'd0, vld}, 24'd1);
    idx_sel = 2'd3; xk = 4'h1; ix = 16'h0100;
    issue(4'd0, 20'hFFFFF);
    chk("R1 sel3 zero-ext", {4'd0, ea}, 24'h0101FF);
  endtask

  task automatic t_idx16;
    idx_sel = 2'd1; yk = 4'h2; iy = 16'h0010;
    issue(4'd1, 20'h08000);
    chk("R2 negative word", {4'd0, ea}, 24'h018010);
    chk("R2 wb_en", {23'd0, wb_en}, 24'd0);
    iy = 16'hF000;
    issue(4'd1, 20'h02000);
    chk("R2 positive carry", {4'd0, ea}, 24'h031000);
  endtask

  task automatic t_idx20;
    idx_sel = 2'd2; zk = 4'h0; iz = 16'h1000;
    issue(4'd2, 20'hFFFFF);
    chk("R3 minus one", {4'd0, ea}, 24'h000FFF);
    zk = 4'hF; iz = 16'hFFFF;
    issue(4'd2, 20'h00002);
    chk("R3 wrap 2^20", {4'd0, ea}, 24'h000001);
  endtask

  task automatic t_acc;
    idx_sel = 2'd0; xk = 4'h1; ix = 16'h8000; acc_e = 16'h9000; acc_d = 16'h1234;
    issue(4'd3, 20'h0);
    chk("R4 acc E", {4'd0, ea}, 24'h011000);
    idx_sel = 2'd1; yk = 4'h5; iy = 16'h0000;
    issue(4'd8, 20'h0);
    chk("R4 acc D", {4'd0, ea}, 24'h051234);
  endtask

  task automatic t_ext;
    dext = 4'h7;
    issue(4'd4, 20'hFABCD);
    chk("R5 ea", {4'd0, ea}, 24'h07ABCD);
    chk("R9 ext low half", ext_addr, 24'h07ABCD);
    dext = 4'hC;
    issue(4'd4, 20'h00001);
    chk("R9 ext upper copy", ext_addr, 24'hFC0001);
  endtask

  task automatic t_post;
    xk = 4'h2; ix = 16'hFFFE;
    issue(4'd5, 20'h00005);
    chk("R6 ea", {4'd0, ea}, 24'h02FFFE);
    chk("R6 wb_val", {4'd0, wb_val}, 24'h030003);
    chk("R6 wb_en/sel", {21'd0, wb_en, wb_sel}, 24'h000004);
    xk = 4'h0; ix = 16'h0010;
    issue(4'd5, 20'h00080);
    chk("R6 negative wb", {4'd0, wb_val}, 24'h0FFF90);
  endtask

  task automatic t_rel;
    pk = 4'h4; pc = 16'hFFF0; rel_word = 1'b0; br_taken = 1'b1;
    issue(4'd6, 20'h00020);
    chk("R7 taken byte no bank change", {4'd0, ea}, 24'h040010);
    br_taken = 1'b0;
    issue(4'd6, 20'h00020);
    chk("R7 not taken", {4'd0, ea}, 24'h04FFF0);
    pc = 16'h1000; rel_word = 1'b1; br_taken = 1'b1;
    issue(4'd6, 20'h08000);
    chk("R7 taken word", {4'd0, ea}, 24'h049000);
    chk("R7 wb_en", {23'd0, wb_en}, 24'd0);
  endtask

  task automatic t_aimm;
    idx_sel = 2'd2; zk = 4'h1; iz = 16'hFFFF;
    issue(4'd7, 20'h00001);
    chk("R8 ea", {4'd0, ea}, 24'h020000);
    chk("R8 wb_val", {4'd0, wb_val}, 24'h020000);
    chk("R8 wb_en/sel Z", {21'd0, wb_en, wb_sel}, 24'h000006);
    idx_sel = 2'd1; yk = 4'h3; iy = 16'h0000;
    issue(4'd7, 20'h000FF);
    chk("R8 negative Y", {4'd0, wb_val}, 24'h02FFFF);
    chk("R8 wb_sel Y", {22'd0, wb_sel}, 24'h000001);
  endtask

  task automatic t_unused;
    for (int m = 9; m < 16; m++) begin
      issue(m[3:0], 20'h12345);
      chk("R12 ea", {4'd0, ea}, 24'd0);
      chk("R12 wb_en", {23'd0, wb_en}, 24'd0);
    end
  endtask

  task automatic t_hold;
    dext = 4'h9;
    issue(4'd4, 20'h05555);
    chk("R10 loaded", {4'd0, ea}, 24'h095555);
    mode = 4'd4; opnd = 20'h0AAAA; dext = 4'h1;
    @(negedge clk);
    chk("R10 vld low", {23'd0, vld}, 24'd0);
    chk("R10 ea held", {4'd0, ea}, 24'h095555);
    @(negedge clk);
    chk("R10 ext held", ext_addr, 24'hF95555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idx8();
    t_idx16();
    t_idx20();
    t_acc();
    t_ext();
    t_post();
    t_rel();
    t_aimm();
    t_unused();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule